// File: doc/BRIEF.md
# SMBus Host Transaction Control Unit

This unit is the register-side control and status logic of an SMBus host controller. Software programs a transaction through a small synchronous register port. It loads a protocol code, a target address, a command byte, two data bytes and interrupt options, then sets a start bit. The unit hands the transaction parameters to an external bus engine over a valid/ready launch handshake. It tracks a busy flag while the engine works, and records how the transaction ended: normal completion, error, or abort requested by software.

Each ending sets a sticky status flag. Software clears these flags by writing ones to them. When interrupts are enabled, any set flag drives one of two interrupt outputs, chosen by a routing bit: a general-purpose interrupt line or a system-management interrupt line. On normal completion the engine's two result bytes are written back into the data registers. A new transaction therefore overwrites whatever the previous one left there.

The launch handshake follows the usual rule. `launch_valid` stays high with stable parameters until `launch_ready` is sampled high, and the transfer happens on the edge where both are high. The engine may hold `launch_ready` low for as long as it needs. The engine reports (`eng_done`, `eng_err`, `eng_kill_ack`) are single-cycle pulses. They are only honoured after the launch has been accepted.

Top module: `smbh_ctrl`

## Requirements
- R1: After reset, every register reads zero, the busy flag is low, `launch_valid` and `eng_kill` are low, and both interrupt outputs are low.
- R2: While idle, writes to the command (address 2), target (address 3), data0 (address 4), data1 (address 5) and control (address 1) registers read back as written and appear on the launch parameter ports. The control register holds interrupt enable in bit 0, kill in bit 1, route in bit 2, protocol in bits 6:4 and start in bit 7.
- R3: A control write with bit 7 set, made while idle with no status flag set, raises `launch_valid` and the busy flag (status bit 0) at that write's clock edge. `launch_valid` is held until `launch_ready` is sampled high. The start bit then reads back as 0.
- R4: A start request made while any status flag is set has no effect: `launch_valid` and busy stay low.
- R5: Busy stays high from the start write until a completion, error or acknowledged abort is sampled after the launch was accepted. It drops at that same edge.
- R6: While busy, writes to the command, target, data and control registers are ignored, except for the kill bit of the control register.
- R7: A completion pulse sets the done flag (status bit 1) and loads `eng_res0`/`eng_res1` into data0/data1.
- R8: An error pulse sets the error flag (status bit 2) and leaves the data registers unchanged.
- R9: Writing kill while busy raises `eng_kill` once the launch has been accepted, and holds it until `eng_kill_ack`. The acknowledge edge clears busy and `eng_kill` and sets the abort flag (status bit 3). Kill reads as 1 while the abort is pending.
- R10: Writing to the status register (address 0) clears each flag whose write bit is 1 and keeps each flag whose write bit is 0.
- R11: `irq_gen` equals enable AND any flag set, when route is 0. `irq_smi` equals the same, when route is 1. The non-selected line stays low, and both fall once all flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| launch_valid | output | 1 | Transaction launch request |
| launch_ready | input | 1 | Engine accepts the launch |
| launch_proto | output | 3 | Protocol code |
| launch_target | output | 8 | Target device address |
| launch_cmd | output | 8 | Command byte |
| launch_data0 | output | 8 | Data byte 0 |
| launch_data1 | output | 8 | Data byte 1 |
| eng_kill | output | 1 | Abort request to the engine |
| eng_kill_ack | input | 1 | Engine acknowledges the abort |
| eng_done | input | 1 | Engine reports normal completion |
| eng_err | input | 1 | Engine reports an error |
| eng_res0 | input | 8 | Result byte written into data0 on completion |
| eng_res1 | input | 8 | Result byte written into data1 on completion |
| irq_gen | output | 1 | General interrupt output |
| irq_smi | output | 1 | System-management interrupt output |

## Verification
Every result of this block becomes visible at the clock edge that samples its cause. A register write, a start, or a kill request shows in the register reads and the launch/kill outputs right after its write edge. A completion, error, acknowledge or handshake shows in busy, the flags, the data registers and the interrupt lines right after the edge that samples the pulse. The interrupt lines add no extra cycle, because they are combinational on the flags. The bench drives every stimulus on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each check therefore lands in the first cycle its result is due.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int ADR_STAT = 0;
  localparam int ADR_CTRL = 1;
  localparam int ADR_CMD  = 2;
  localparam int ADR_TGT  = 3;
  localparam int ADR_DAT0 = 4;

  localparam int C_IEN   = 0;
  localparam int C_KILL  = 1;
  localparam int C_ROUTE = 2;
  localparam int C_PLO   = 4;
  localparam int C_START = 7;

  localparam int NFLAG = 3;  // done, error, abort

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_RUN,
    SQ_ABORT
  } seq_e;
endpackage

// File: rtl/smbh_regs.sv
module smbh_regs
  import smbh_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PW   = 3,
  parameter int AW   = 3,
  parameter int NDAT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               busy,
  input  logic               res_load,
  input  logic [NDAT*DW-1:0] res,
  output logic               irq_en,
  output logic               route,
  output logic [PW-1:0]      proto,
  output logic [DW-1:0]      cmd,
  output logic [DW-1:0]      tgt,
  output logic [NDAT*DW-1:0] dat
);
  logic open_wr;
  assign open_wr = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      route  <= 1'b0;
      proto  <= '0;
      cmd    <= '0;
      tgt    <= '0;
    end else if (open_wr) begin
      if (addr == AW'(ADR_CTRL)) begin
        irq_en <= wdata[C_IEN];
        route  <= wdata[C_ROUTE];
        proto  <= wdata[C_PLO +: PW];
      end
      if (addr == AW'(ADR_CMD)) cmd <= wdata;
      if (addr == AW'(ADR_TGT)) tgt <= wdata;
    end
  end

  for (genvar g = 0; g < NDAT; g++) begin : g_dat
    always_ff @(posedge clk) begin
      if (!rst_n)
        dat[g*DW +: DW] <= '0;
      else if (res_load)
        dat[g*DW +: DW] <= res[g*DW +: DW];
      else if (open_wr && addr == AW'(ADR_DAT0 + g))
        dat[g*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic kill_req,
  input  logic launch_ready,
  input  logic done,
  input  logic err,
  input  logic kill_ack,
  output logic busy,
  output logic launch_valid,
  output logic eng_kill,
  output logic kill_flag,
  output logic fin_done,
  output logic fin_err,
  output logic fin_kill
);
  seq_e st_q, st_d;
  logic kpend_q, kpend_d;

  always_comb begin
    st_d     = st_q;
    kpend_d  = kpend_q;
    fin_done = 1'b0;
    fin_err  = 1'b0;
    fin_kill = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        kpend_d = 1'b0;
        if (start_req) st_d = SQ_LAUNCH;
      end
      SQ_LAUNCH: begin
        if (kill_req) kpend_d = 1'b1;
        if (launch_ready) begin
          st_d    = (kpend_q || kill_req) ? SQ_ABORT : SQ_RUN;
          kpend_d = 1'b0;
        end
      end
      SQ_RUN: begin
        if (done) begin
          st_d = SQ_IDLE; fin_done = 1'b1;
        end else if (err) begin
          st_d = SQ_IDLE; fin_err = 1'b1;
        end else if (kill_req) begin
          st_d = SQ_ABORT;
        end
      end
      SQ_ABORT: begin
        if (kill_ack) begin
          st_d = SQ_IDLE; fin_kill = 1'b1;
        end else if (done) begin
          st_d = SQ_IDLE; fin_done = 1'b1;
        end else if (err) begin
          st_d = SQ_IDLE; fin_err = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      kpend_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      kpend_q <= kpend_d;
    end
  end

  assign busy         = (st_q != SQ_IDLE);
  assign launch_valid = (st_q == SQ_LAUNCH);
  assign eng_kill     = (st_q == SQ_ABORT);
  assign kill_flag    = kpend_q || eng_kill;
endmodule

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             clr_en,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic             irq_en,
  input  logic             route,
  output logic [NFLAG-1:0] flags,
  output logic             any,
  output logic             irq_gen,
  output logic             irq_smi
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[g] <= 1'b0;
      else if (set_vec[g])
        flags[g] <= 1'b1;
      else if (clr_en && clr_mask[g])
        flags[g] <= 1'b0;
    end
  end

  logic fire;
  assign any     = |flags;
  assign fire    = irq_en && any;
  assign irq_gen = fire && !route;
  assign irq_smi = fire && route;
endmodule

// File: rtl/smbh_ctrl.sv
module smbh_ctrl
  import smbh_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 3,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          launch_valid,
  input  logic          launch_ready,
  output logic [PW-1:0] launch_proto,
  output logic [DW-1:0] launch_target,
  output logic [DW-1:0] launch_cmd,
  output logic [DW-1:0] launch_data0,
  output logic [DW-1:0] launch_data1,
  output logic          eng_kill,
  input  logic          eng_kill_ack,
  input  logic          eng_done,
  input  logic          eng_err,
  input  logic [DW-1:0] eng_res0,
  input  logic [DW-1:0] eng_res1,
  output logic          irq_gen,
  output logic          irq_smi
);
  localparam int NDAT = 2;

  logic busy, st_any, irq_en, route, kill_flag;
  logic fin_done, fin_err, fin_kill;
  logic [NFLAG-1:0] flags;
  logic [NDAT*DW-1:0] dat;
  logic ctrl_wr, start_req, kill_req;

  assign ctrl_wr   = reg_wr && reg_addr == AW'(ADR_CTRL);
  assign start_req = ctrl_wr && reg_wdata[C_START] && !busy && !st_any;
  assign kill_req  = ctrl_wr && reg_wdata[C_KILL] && busy;

  smbh_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .kill_req     (kill_req),
    .launch_ready (launch_ready),
    .done         (eng_done),
    .err          (eng_err),
    .kill_ack     (eng_kill_ack),
    .busy         (busy),
    .launch_valid (launch_valid),
    .eng_kill     (eng_kill),
    .kill_flag    (kill_flag),
    .fin_done     (fin_done),
    .fin_err      (fin_err),
    .fin_kill     (fin_kill)
  );

  smbh_regs #(.DW(DW), .PW(PW), .AW(AW), .NDAT(NDAT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .res_load (fin_done),
    .res      ({eng_res1, eng_res0}),
    .irq_en   (irq_en),
    .route    (route),
    .proto    (launch_proto),
    .cmd      (launch_cmd),
    .tgt      (launch_target),
    .dat      (dat)
  );

  smbh_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  ({fin_kill, fin_err, fin_done}),
    .clr_en   (reg_wr && reg_addr == AW'(ADR_STAT)),
    .clr_mask (reg_wdata[NFLAG:1]),
    .irq_en   (irq_en),
    .route    (route),
    .flags    (flags),
    .any      (st_any),
    .irq_gen  (irq_gen),
    .irq_smi  (irq_smi)
  );

  assign launch_data0 = dat[0 +: DW];
  assign launch_data1 = dat[DW +: DW];

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_addr))
      ADR_STAT: reg_rdata[NFLAG:0] = {flags, busy};
      ADR_CTRL: begin
        reg_rdata[C_IEN]       = irq_en;
        reg_rdata[C_KILL]      = kill_flag;
        reg_rdata[C_ROUTE]     = route;
        reg_rdata[C_PLO +: PW] = launch_proto;
        reg_rdata[C_START]     = launch_valid;
      end
      ADR_CMD:      reg_rdata = launch_cmd;
      ADR_TGT:      reg_rdata = launch_target;
      ADR_DAT0:     reg_rdata = launch_data0;
      ADR_DAT0 + 1: reg_rdata = launch_data1;
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/smbh_ctrl_chk.sv
module smbh_ctrl_chk
  import smbh_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          busy,
  input logic          st_any,
  input logic          launch_valid,
  input logic          launch_ready,
  input logic          eng_kill,
  input logic          eng_kill_ack,
  input logic          eng_done,
  input logic          eng_err,
  input logic [DW-1:0] launch_cmd,
  input logic          irq_gen,
  input logic          irq_smi
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid && !launch_ready |=> launch_valid);

  assert_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> busy);

  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == AW'(ADR_CTRL) && reg_wdata[C_START] && !busy && st_any
    |=> !launch_valid && !busy);

  assert_busy_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !eng_done && !eng_err && !(eng_kill && eng_kill_ack) |=> busy);

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_addr == AW'(ADR_CMD) |=> $stable(launch_cmd));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_kill && eng_kill_ack |=> !busy && !eng_kill && st_any);

  assert_kill_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_kill |-> !launch_valid);

  assert_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_gen, irq_smi}));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_gen || irq_smi) |-> st_any);
endmodule

bind smbh_ctrl smbh_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .busy         (busy),
  .st_any       (st_any),
  .launch_valid (launch_valid),
  .launch_ready (launch_ready),
  .eng_kill     (eng_kill),
  .eng_kill_ack (eng_kill_ack),
  .eng_done     (eng_done),
  .eng_err      (eng_err),
  .launch_cmd   (launch_cmd),
  .irq_gen      (irq_gen),
  .irq_smi      (irq_smi)
);

// File: tb/test_smbh_ctrl.sv
`timescale 1ns/1ps
module test_smbh_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic launch_valid, launch_ready = 1'b0;
  logic [2:0] launch_proto;
  logic [7:0] launch_target, launch_cmd, launch_data0, launch_data1;
  logic eng_kill, eng_kill_ack = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic [7:0] eng_res0 = '0, eng_res1 = '0;
  logic irq_gen, irq_smi;

  always #10 clk = ~clk;  // 50 MHz

  smbh_ctrl i_smbh_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_proto(launch_proto), .launch_target(launch_target),
    .launch_cmd(launch_cmd), .launch_data0(launch_data0),
    .launch_data1(launch_data1), .eng_kill(eng_kill),
    .eng_kill_ack(eng_kill_ack), .eng_done(eng_done), .eng_err(eng_err),
    .eng_res0(eng_res0), .eng_res1(eng_res1),
    .irq_gen(irq_gen), .irq_smi(irq_smi)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // expected model
  logic       m_en, m_route;
  logic [2:0] m_proto, m_st;  // m_st: bit0 done, bit1 error, bit2 abort
  logic [7:0] m_cmd, m_tgt, m_d0, m_d1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] ctrl_word(input logic st, input logic kl);
    return {st, m_proto, 1'b0, m_route, kl, m_en};
  endfunction

  function automatic logic [1:0] exp_irq();
    if (m_en && |m_st) return m_route ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  task automatic chk_stat(input string tag, input logic bsy);
    logic [7:0] v;
    rd(3'd0, v);
    chk(tag, v, {4'b0, m_st, bsy});
  endtask

  task automatic chk_irq(input string tag);
    chk(tag, {irq_smi, irq_gen}, exp_irq());
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    m_en = 0; m_route = 0; m_proto = 0; m_st = 0;
    m_cmd = 0; m_tgt = 0; m_d0 = 0; m_d1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg after reset", v, 8'h00);
    end
    chk("R1 launch_valid", launch_valid, 0);
    chk("R1 eng_kill", eng_kill, 0);
    chk("R1 irq", {irq_smi, irq_gen}, 0);

    for (int it = 0; it < 40; it++) begin
      int outcome, waits;
      logic early;
      logic [7:0] r0, r1, mask;
      // R2: configure while idle
      m_cmd = 8'($urandom); m_tgt = 8'($urandom);
      m_d0 = 8'($urandom); m_d1 = 8'($urandom);
      m_en = 1'($urandom); m_route = 1'($urandom); m_proto = 3'($urandom);
      wr(3'd2, m_cmd); wr(3'd3, m_tgt); wr(3'd4, m_d0); wr(3'd5, m_d1);
      wr(3'd1, ctrl_word(0, 0));
      rd(3'd1, v); chk("R2 ctrl readback", v, ctrl_word(0, 0));
      rd(3'd2, v); chk("R2 cmd readback", v, m_cmd);
      rd(3'd5, v); chk("R2 data1 readback", v, m_d1);
      chk("R2 launch ports", {launch_proto, launch_target, launch_cmd, launch_data0, launch_data1},
          {m_proto, m_tgt, m_cmd, m_d0, m_d1});

      // R3: start
      wr(3'd1, ctrl_word(1, 0));
      chk("R3 launch_valid after start", launch_valid, 1);
      chk_stat("R3 busy after start", 1);
      waits = int'($urandom % 4);
      repeat (waits) @(negedge clk);
      chk("R3 valid held without ready", launch_valid, 1);

      // R6: writes while busy ignored
      wr(3'd2, 8'($urandom));
      rd(3'd2, v); chk("R6 cmd frozen", v, m_cmd);
      wr(3'd4, 8'($urandom));
      rd(3'd4, v); chk("R6 data0 frozen", v, m_d0);
      wr(3'd1, 8'($urandom) & 8'hFD);
      rd(3'd1, v); chk("R6 ctrl frozen", v, ctrl_word(1, 0));

      outcome = int'($urandom % 3);
      early = (outcome == 2) && 1'($urandom);
      if (early) begin
        wr(3'd1, 8'($urandom) | 8'h02);
        chk("R9 kill deferred during launch", eng_kill, 0);
        rd(3'd1, v); chk("R9 kill pending reads 1", v, ctrl_word(1, 1));
      end

      @(negedge clk); launch_ready = 1'b1;
      @(negedge clk); launch_ready = 1'b0;
      chk("R3 valid drops after handshake", launch_valid, 0);
      rd(3'd1, v); chk("R3 start self-clears", v, ctrl_word(0, early));
      repeat (2) @(negedge clk);
      chk_stat("R5 busy while running", 1);

      if (outcome == 2) begin
        if (!early) wr(3'd1, 8'($urandom) | 8'h02);
        chk("R9 eng_kill raised", eng_kill, 1);
        rd(3'd1, v); chk("R9 kill reads 1 while aborting", v, ctrl_word(0, 1));
        @(negedge clk); eng_kill_ack = 1'b1;
        @(negedge clk); eng_kill_ack = 1'b0;
        m_st[2] = 1'b1;
        chk("R9 eng_kill released", eng_kill, 0);
      end else if (outcome == 0) begin
        r0 = 8'($urandom); r1 = 8'($urandom);
        @(negedge clk); eng_done = 1'b1; eng_res0 = r0; eng_res1 = r1;
        @(negedge clk); eng_done = 1'b0;
        m_d0 = r0; m_d1 = r1; m_st[0] = 1'b1;
      end else begin
        @(negedge clk); eng_err = 1'b1; eng_res0 = 8'($urandom); eng_res1 = 8'($urandom);
        @(negedge clk); eng_err = 1'b0;
        m_st[1] = 1'b1;
      end
      chk_stat(outcome == 0 ? "R7 done flag" : (outcome == 1 ? "R8 error flag" : "R9 abort flag"), 0);
      rd(3'd4, v); chk(outcome == 0 ? "R7 data0 result" : "R8 data0 kept", v, m_d0);
      rd(3'd5, v); chk(outcome == 0 ? "R7 data1 result" : "R8 data1 kept", v, m_d1);
      chk_irq("R11 irq routing");

      // R4: start while a flag is set
      wr(3'd1, ctrl_word(1, 0));
      chk("R4 no launch with flags set", launch_valid, 0);
      chk_stat("R4 not busy", 0);

      // R10: partial write-one-to-clear
      mask = 8'($urandom) & 8'h0E;
      wr(3'd0, mask);
      m_st = m_st & ~mask[3:1];
      chk_stat("R10 w1c partial", 0);
      chk_irq("R11 irq after partial clear");
      wr(3'd0, 8'h0E);
      m_st = 3'b000;
      chk_stat("R10 all cleared", 0);
      chk("R11 irq deasserted", {irq_smi, irq_gen}, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule